// File: doc/BRIEF.md
# PCI Initiator Termination Controller

This block sits beside the bus-master engine of a PCI bridge port and decides, clock by clock, when the master should end its current transaction. It watches whether a target claims the transaction in time, how many DWORDs have been accepted, whether the transfer has reached its natural end for its kind, whether the master latency timer has run out with the grant removed, and whether the target has asked to end things. It reports a one-cycle terminate request together with the reason: a master abort, or a resumable cut-off that needs a follow-up transaction.

The controller tells the transaction kinds apart because they end differently. Single-DWORD kinds stop after one data phase. Prefetching reads stop at the prefetch boundary. Buffered writes stop when their buffer runs dry. Bursts may also be cut off by the latency timer. When such a cut-off hits a buffered write, the controller also gives the DWORD address at which the follow-up transaction has to resume. Pin-level handshakes and the data path stay with the surrounding logic. That logic pulses a start strobe in the cycle the initiator drives FRAME and then feeds in the per-cycle bus observations.

Top module: `pci_init_term_ctrl`

## Requirements
- R1: After a start, if the claim input (`devsel_i`) stays low through five consecutive clocks, the controller terminates with `mabort_o`. A claim seen in the fifth of those clocks gives a normal transaction.
- R2: A delayed write (kind code 0) terminates after exactly one accepted DWORD.
- R3: A non-prefetchable read (kind code 2) terminates after exactly one received DWORD.
- R4: A prefetchable read (kind code 3) terminates on the data phase that carries `pf_bnd_i`.
- R5: A posted write (kind code 1) terminates on the data phase that carries `last_i`, with no reissue.
- R6: A posted write or prefetchable read terminates on a data-state clock where the latency timer is expired and `gnt_i` is low. While `gnt_i` stays high it continues.
- R7: Memory write and invalidate (kind code 4) ignores latency timer expiry and terminates only on `last_i` or a target termination.
- R8: A posted write ended by the latency rule raises `reissue_o`. `reissue_addr_o` is then the start address plus four times the number of DWORDs accepted, including the one in the final clock.
- R9: A prefetchable read ended by the latency rule does not raise `reissue_o`.
- R10: A target termination ends the transaction with no reissue. The codes on `tterm_i` are 1 retry, 2 disconnect, 3 target abort. A disconnect that carries `data_i` counts that DWORD.
- R11: The latency timer loads `lat_i` on start and counts down once per clock while the controller is busy, including the claim wait. It is expired at zero, so a value of 0 is already expired on the first data phase.
- R12: When natural completion and latency expiry fall on the same clock, the transaction counts as completed and no reissue is raised.
- R13: Reset clears all outputs to zero. `term_o` is a one-clock pulse, registered one clock after the deciding edge. `busy_o` is high from the clock after start until termination. A start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Initiator asserted FRAME this clock; begins a transaction |
| kind_i | input | 3 | Transaction kind code, sampled with start |
| addr_i | input | AW | Starting DWORD address, sampled with start |
| lat_i | input | TW | Master latency timer reload value, sampled with start |
| devsel_i | input | 1 | Target claim seen (DEVSEL active) |
| data_i | input | 1 | A DWORD was accepted this clock |
| last_i | input | 1 | The write buffer empties with this data phase |
| pf_bnd_i | input | 1 | Prefetch boundary reached with this data phase |
| gnt_i | input | 1 | Bus grant still held |
| tterm_i | input | 2 | Target termination class (0 none, 1 retry, 2 disconnect, 3 abort) |
| busy_o | output | 1 | Transaction in progress |
| term_o | output | 1 | Terminate request pulse |
| mabort_o | output | 1 | Termination is a master abort |
| reissue_o | output | 1 | Follow-up transaction required for remaining write data |
| reissue_addr_o | output | AW | DWORD address for the follow-up transaction |

## Verification
The bench aims at both edges of the claim window. A window that is one clock short aborts a transaction claimed in the fifth clock, and one that is one clock long completes a transaction that should abort. It probes the latency count with small reload values, including zero and expiry during the claim wait. An off-by-one timer changes the number of DWORDs before the cut-off and so shifts the resume address by four. It also covers the clock where completion and expiry coincide, a grant held past expiry, and the memory-write-and-invalidate exemption. A design with the wrong priority or a missing exemption would raise a spurious reissue there, or would stop the burst early.

// File: rtl/pit_pkg.sv
// Package: shared codes for the initiator termination controller.
// Assumes kind and target-termination codes are fixed by the surrounding engine.
package pit_pkg;

    typedef enum logic [2:0] {
        K_DWR  = 3'd0,   // delayed write, single DWORD
        K_PWR  = 3'd1,   // posted write burst
        K_NPRD = 3'd2,   // non-prefetchable read, single DWORD
        K_PFRD = 3'd3,   // prefetchable read burst
        K_MWI  = 3'd4    // memory write and invalidate
    } xact_kind_e;

    typedef enum logic [1:0] {
        TT_NONE  = 2'd0,
        TT_RETRY = 2'd1,
        TT_DISC  = 2'd2,
        TT_ABORT = 2'd3
    } tgt_term_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,   // FRAME driven, waiting for a claim
        ST_DATA = 2'd2    // claimed, data phases running
    } ctl_state_e;

    localparam int DWORD_SHIFT = 2;

endpackage

// File: rtl/pit_lat_timer.sv
// Master latency timer: loads a reload value on start and counts down to zero
// once per clock while running. Assumes load and run are never both needed
// in one clock (load wins).
module pit_lat_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          run_i,
    input  logic [TW-1:0] load_val_i,
    output logic          expired_o
);

    logic [TW-1:0] value_q;

    // Purpose: reload on start, otherwise decrement until zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value_q <= '0;
        end else if (load_i) begin
            value_q <= load_val_i;
        end else if (run_i && (value_q != '0)) begin
            value_q <= value_q - 1'b1;
        end
    end

    assign expired_o = (value_q == '0);

    p_timer_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && run_i && value_q != '0) |=> (value_q == $past(value_q) - 1'b1));

    p_timer_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !run_i) |=> $stable(value_q));

endmodule

// File: rtl/pit_devsel_watch.sv
// Claim window watcher: counts clocks spent waiting for a target claim and
// flags a timeout in the last clock of the window if no claim is seen.
// Assumes the window is at least one clock.
module pit_devsel_watch #(
    parameter int WAIT_CLKS = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic in_wait_i,
    input  logic devsel_i,
    output logic timeout_o
);

    localparam int WCW = (WAIT_CLKS > 1) ? $clog2(WAIT_CLKS) : 1;
    localparam logic [WCW-1:0] LAST_CNT = WCW'(WAIT_CLKS - 1);

    logic [WCW-1:0] cnt_q;

    // Purpose: clear on start, advance every waiting clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (arm_i) begin
            cnt_q <= '0;
        end else if (in_wait_i && !devsel_i && cnt_q != LAST_CNT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign timeout_o = in_wait_i && !devsel_i && (cnt_q == LAST_CNT);

    p_window_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_wait_i |-> (cnt_q <= LAST_CNT));

endmodule

// File: rtl/pit_dword_track.sv
// DWORD tracker: remembers the start address and counts accepted DWORDs,
// offering the address of the next undelivered DWORD (including a DWORD
// accepted in the current clock).
module pit_dword_track
    import pit_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [AW-1:0] base_i,
    input  logic          accept_i,
    output logic [AW-1:0] next_addr_o
);

    logic [AW-1:0] base_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_next;

    // Purpose: capture base and clear count on start, count accepted DWORDs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (load_i) begin
            base_q <= base_i;
            cnt_q  <= '0;
        end else if (accept_i) begin
            cnt_q  <= cnt_next;
        end
    end

    // Purpose: count including this clock's DWORD, scaled to a byte address.
    always_comb begin
        cnt_next    = cnt_q + CW'(accept_i);
        next_addr_o = base_q + (AW'(cnt_next) << DWORD_SHIFT);
    end

    p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_i && !load_i) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/pit_term_decide.sv
// Termination decision: per clock, combines claim timeout, transaction kind,
// data-phase events, latency expiry and target termination into abort, end
// and reissue decisions. Natural completion and target termination take
// precedence over the latency cut-off.
module pit_term_decide
    import pit_pkg::*;
(
    input  xact_kind_e kind_i,
    input  logic       in_wait_i,
    input  logic       in_data_i,
    input  logic       timeout_i,
    input  logic       data_i,
    input  logic       last_i,
    input  logic       pf_bnd_i,
    input  logic       gnt_i,
    input  logic       expired_i,
    input  tgt_term_e  tterm_i,
    output logic       abort_o,
    output logic       end_o,
    output logic       reissue_o
);

    logic natural_end;
    logic burst_kind;
    logic lat_cut;

    // Purpose: natural completion by transaction kind on an accepted DWORD.
    always_comb begin
        natural_end = 1'b0;
        if (data_i) begin
            case (kind_i)
                K_PFRD:       natural_end = pf_bnd_i;
                K_PWR, K_MWI: natural_end = last_i;
                default:      natural_end = 1'b1;
            endcase
        end
    end

    // Purpose: latency cut-off applies to the burst kinds only.
    always_comb begin
        burst_kind = (kind_i == K_PWR) || (kind_i == K_PFRD);
        lat_cut    = burst_kind && expired_i && !gnt_i;
    end

    // Purpose: final decisions with precedence target > natural > latency.
    always_comb begin
        abort_o   = in_wait_i && timeout_i;
        end_o     = 1'b0;
        reissue_o = 1'b0;
        if (in_data_i) begin
            if (tterm_i != TT_NONE) begin
                end_o = 1'b1;
            end else if (natural_end) begin
                end_o = 1'b1;
            end else if (lat_cut) begin
                end_o     = 1'b1;
                reissue_o = (kind_i == K_PWR);
            end
        end
    end

endmodule

// File: rtl/pci_init_term_ctrl.sv
// PCI initiator termination controller (top). Tracks one master transaction
// from start through the claim wait and data phases and issues a registered
// terminate pulse with its reason. Assumes start is pulsed in the clock the
// initiator drives FRAME and that per-clock bus observations are valid
// while busy.
module pci_init_term_ctrl
    import pit_pkg::*;
#(
    parameter int AW          = 32,
    parameter int TW          = 8,
    parameter int CW          = 12,
    parameter int DEVSEL_WAIT = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [2:0]    kind_i,
    input  logic [AW-1:0] addr_i,
    input  logic [TW-1:0] lat_i,
    input  logic          devsel_i,
    input  logic          data_i,
    input  logic          last_i,
    input  logic          pf_bnd_i,
    input  logic          gnt_i,
    input  logic [1:0]    tterm_i,
    output logic          busy_o,
    output logic          term_o,
    output logic          mabort_o,
    output logic          reissue_o,
    output logic [AW-1:0] reissue_addr_o
);

    ctl_state_e    state_q;
    xact_kind_e    kind_q;
    logic          term_q;
    logic          mab_q;
    logic          reis_q;
    logic [AW-1:0] raddr_q;

    logic          start_ok;
    logic          in_wait;
    logic          in_data;
    logic          expired;
    logic          timeout;
    logic          abort_now;
    logic          end_now;
    logic          reissue_now;
    logic [AW-1:0] next_addr;

    // Purpose: qualify the start strobe and decode the state.
    always_comb begin
        start_ok = start_i && (state_q == ST_IDLE);
        in_wait  = (state_q == ST_WAIT);
        in_data  = (state_q == ST_DATA);
    end

    pit_lat_timer #(.TW(TW)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (start_ok),
        .run_i      (state_q != ST_IDLE),
        .load_val_i (lat_i),
        .expired_o  (expired)
    );

    pit_devsel_watch #(.WAIT_CLKS(DEVSEL_WAIT)) u_watch (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_i     (start_ok),
        .in_wait_i (in_wait),
        .devsel_i  (devsel_i),
        .timeout_o (timeout)
    );

    pit_dword_track #(.AW(AW), .CW(CW)) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (start_ok),
        .base_i      (addr_i),
        .accept_i    (in_data && data_i),
        .next_addr_o (next_addr)
    );

    pit_term_decide u_decide (
        .kind_i    (kind_q),
        .in_wait_i (in_wait),
        .in_data_i (in_data),
        .timeout_i (timeout),
        .data_i    (data_i),
        .last_i    (last_i),
        .pf_bnd_i  (pf_bnd_i),
        .gnt_i     (gnt_i),
        .expired_i (expired),
        .tterm_i   (tgt_term_e'(tterm_i)),
        .abort_o   (abort_now),
        .end_o     (end_now),
        .reissue_o (reissue_now)
    );

    // Purpose: transaction state sequencing and kind capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            kind_q  <= K_DWR;
        end else begin
            case (state_q)
                ST_IDLE: if (start_ok) begin
                    state_q <= ST_WAIT;
                    kind_q  <= xact_kind_e'(kind_i);
                end
                ST_WAIT: if (abort_now) state_q <= ST_IDLE;
                         else if (devsel_i) state_q <= ST_DATA;
                ST_DATA: if (end_now) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Purpose: register the termination pulse, its reason and resume address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            term_q  <= 1'b0;
            mab_q   <= 1'b0;
            reis_q  <= 1'b0;
            raddr_q <= '0;
        end else begin
            term_q <= abort_now || end_now;
            mab_q  <= abort_now;
            reis_q <= reissue_now;
            if (reissue_now) raddr_q <= next_addr;
        end
    end

    assign busy_o         = (state_q != ST_IDLE);
    assign term_o         = term_q;
    assign mabort_o       = mab_q;
    assign reissue_o      = reis_q;
    assign reissue_addr_o = raddr_q;

    p_abort_terms_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mabort_o |-> (term_o && !reissue_o));

    p_abort_from_wait_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mabort_o |-> ($past(state_q) == ST_WAIT));

    p_reissue_pwr_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reissue_o |-> (term_o && kind_q == K_PWR));

    p_term_one_cycle_r13: assert property (@(posedge clk) disable iff (!rst_n)
        term_o |=> !term_o);

    p_idle_after_term_r13: assert property (@(posedge clk) disable iff (!rst_n)
        term_o |-> !busy_o);

endmodule

// File: tb/pci_init_term_ctrl_tb.sv
`timescale 1ns/1ps
module pci_init_term_ctrl_tb;

    localparam int AW = 32;
    localparam int TW = 8;
    localparam int NV = 16;

    // Vector fields: kind, claim delay, latency reload, boundary phase,
    // buffer-empty phase, first phase without grant, target term code,
    // target term phase, expected DWORDs, expected abort, expected reissue,
    // expected resume offset in bytes. 255 means never.
    typedef struct packed {
        logic [2:0] kind;
        logic [3:0] sel;
        logic [7:0] lat;
        logic [7:0] bnd;
        logic [7:0] emp;
        logic [7:0] gdrop;
        logic [1:0] tt;
        logic [7:0] tt_at;
        logic [7:0] en;
        logic       ema;
        logic       eri;
        logic [7:0] eoff;
    } vec_t;

    localparam vec_t VECS [0:NV-1] = '{
        '{3'd0, 4'd0, 8'd200, 8'd255, 8'd255, 8'd255, 2'd0, 8'd255, 8'd1, 1'b0, 1'b0, 8'd0},  // R2
        '{3'd2, 4'd2, 8'd200, 8'd255, 8'd255, 8'd255, 2'd0, 8'd255, 8'd1, 1'b0, 1'b0, 8'd0},  // R3
        '{3'd3, 4'd0, 8'd200, 8'd4,   8'd255, 8'd255, 2'd0, 8'd255, 8'd4, 1'b0, 1'b0, 8'd0},  // R4
        '{3'd1, 4'd0, 8'd200, 8'd255, 8'd6,   8'd255, 2'd0, 8'd255, 8'd6, 1'b0, 1'b0, 8'd0},  // R5
        '{3'd1, 4'd0, 8'd3,   8'd255, 8'd20,  8'd0,   2'd0, 8'd255, 8'd3, 1'b0, 1'b1, 8'd12}, // R8
        '{3'd3, 4'd0, 8'd3,   8'd50,  8'd255, 8'd0,   2'd0, 8'd255, 8'd3, 1'b0, 1'b0, 8'd0},  // R9
        '{3'd4, 4'd0, 8'd2,   8'd255, 8'd8,   8'd0,   2'd0, 8'd255, 8'd8, 1'b0, 1'b0, 8'd0},  // R7
        '{3'd1, 4'd0, 8'd2,   8'd255, 8'd20,  8'd5,   2'd0, 8'd255, 8'd5, 1'b0, 1'b1, 8'd20}, // R6
        '{3'd1, 4'd0, 8'd200, 8'd255, 8'd20,  8'd255, 2'd2, 8'd3,   8'd3, 1'b0, 1'b0, 8'd0},  // R10 disconnect
        '{3'd3, 4'd0, 8'd200, 8'd50,  8'd255, 8'd255, 2'd1, 8'd1,   8'd0, 1'b0, 1'b0, 8'd0},  // R10 retry
        '{3'd2, 4'd0, 8'd200, 8'd255, 8'd255, 8'd255, 2'd3, 8'd1,   8'd0, 1'b0, 1'b0, 8'd0},  // R10 abort
        '{3'd0, 4'd4, 8'd200, 8'd255, 8'd255, 8'd255, 2'd0, 8'd255, 8'd1, 1'b0, 1'b0, 8'd0},  // R1 late claim
        '{3'd0, 4'd5, 8'd200, 8'd255, 8'd255, 8'd255, 2'd0, 8'd255, 8'd0, 1'b1, 1'b0, 8'd0},  // R1 no claim
        '{3'd1, 4'd0, 8'd3,   8'd255, 8'd3,   8'd0,   2'd0, 8'd255, 8'd3, 1'b0, 1'b0, 8'd0},  // R12
        '{3'd1, 4'd0, 8'd0,   8'd255, 8'd20,  8'd0,   2'd0, 8'd255, 8'd1, 1'b0, 1'b1, 8'd4},  // R11 zero
        '{3'd1, 4'd3, 8'd2,   8'd255, 8'd20,  8'd0,   2'd0, 8'd255, 8'd1, 1'b0, 1'b1, 8'd4}   // R11 in wait
    };

    function automatic string tag_of(int i);
        case (i)
            0: return "R2";   1: return "R3";   2: return "R4";   3: return "R5";
            4: return "R8";   5: return "R9";   6: return "R7";   7: return "R6";
            8, 9, 10: return "R10";
            11, 12: return "R1";
            13: return "R12";
            default: return "R11";
        endcase
    endfunction

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start_i, devsel_i, data_i, last_i, pf_bnd_i, gnt_i;
    logic [2:0]    kind_i;
    logic [AW-1:0] addr_i;
    logic [TW-1:0] lat_i;
    logic [1:0]    tterm_i;
    logic          busy_o, term_o, mabort_o, reissue_o;
    logic [AW-1:0] reissue_addr_o;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    always #4 clk = ~clk;

    pci_init_term_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .kind_i(kind_i),
        .addr_i(addr_i), .lat_i(lat_i), .devsel_i(devsel_i), .data_i(data_i),
        .last_i(last_i), .pf_bnd_i(pf_bnd_i), .gnt_i(gnt_i), .tterm_i(tterm_i),
        .busy_o(busy_o), .term_o(term_o), .mabort_o(mabort_o),
        .reissue_o(reissue_o), .reissue_addr_o(reissue_addr_o)
    );

    task automatic check(string req, string what, logic [AW-1:0] act, logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s act %0h exp %0h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        start_i = 0; devsel_i = 0; data_i = 0; last_i = 0; pf_bnd_i = 0;
        gnt_i = 1; tterm_i = 0; kind_i = 0; addr_i = '0; lat_i = '0;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog act %0d exp below 100000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst_n = 0;
        repeat (3) @(negedge clk);
        // R13: reset state
        check("R13", "reset term", 32'(term_o), 0);
        check("R13", "reset busy", 32'(busy_o), 0);
        check("R13", "reset mabort", 32'(mabort_o), 0);
        check("R13", "reset reissue", 32'(reissue_o), 0);
        check("R13", "reset addr", reissue_addr_o, 0);
        rst_n = 1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            logic [AW-1:0] base;
            int n, k, j, guard;
            bit sel, done, ma, ri;
            logic [AW-1:0] ra;
            v = VECS[i];
            base = 32'h4000_0000 + 32'(i) * 32'h100;
            n = 0; k = 0; j = 0; guard = 0; sel = 0; done = 0; ma = 0; ri = 0; ra = '0;
            kind_i = v.kind; addr_i = base; lat_i = v.lat; start_i = 1;
            @(negedge clk);
            start_i = 0;
            while (!done && guard < 100) begin
                guard++;
                if (!sel) begin
                    devsel_i = (k >= int'(v.sel));
                    data_i = 0; last_i = 0; pf_bnd_i = 0; tterm_i = 0; gnt_i = 1;
                end else begin
                    j++;
                    tterm_i  = (j == int'(v.tt_at)) ? v.tt : 2'd0;
                    data_i   = (tterm_i == 2'd0 || tterm_i == 2'd2);
                    pf_bnd_i = (j == int'(v.bnd));
                    last_i   = (j == int'(v.emp));
                    gnt_i    = (j < int'(v.gdrop));
                end
                @(negedge clk);
                if (!sel) begin
                    if (devsel_i) sel = 1;
                    k++;
                end else if (data_i) begin
                    n++;
                end
                if (term_o) begin
                    done = 1; ma = mabort_o; ri = reissue_o; ra = reissue_addr_o;
                end
            end
            idle_inputs();
            check(tag_of(i), $sformatf("vec %0d term seen", i), 32'(done), 1);
            check(tag_of(i), $sformatf("vec %0d dwords", i), 32'(n), 32'(v.en));
            check(tag_of(i), $sformatf("vec %0d mabort", i), 32'(ma), 32'(v.ema));
            check(tag_of(i), $sformatf("vec %0d reissue", i), 32'(ri), 32'(v.eri));
            if (v.eri)
                check(tag_of(i), $sformatf("vec %0d resume addr", i), ra, base + 32'(v.eoff));
            @(negedge clk);
            check("R13", $sformatf("vec %0d term pulse width", i), 32'(term_o), 0);
        end

        // R13: busy after start, a second start while busy ignored, reset mid-transaction
        kind_i = 3'd1; addr_i = 32'h5000_0000; lat_i = 8'd200; start_i = 1;
        @(negedge clk);
        check("R13", "busy after start", 32'(busy_o), 1);
        kind_i = 3'd0; addr_i = 32'h6000_0000;
        @(negedge clk);
        start_i = 0; devsel_i = 1;
        @(negedge clk);
        devsel_i = 1; data_i = 1;
        @(negedge clk);
        // kind 1 captured first: one DWORD without last must not end it
        check("R13", "restart ignored, still busy", 32'(busy_o), 1);
        check("R13", "restart ignored, no term", 32'(term_o), 0);
        rst_n = 0;
        @(negedge clk);
        check("R13", "reset mid busy", 32'(busy_o), 0);
        check("R13", "reset mid term", 32'(term_o), 0);
        rst_n = 1;
        idle_inputs();
        @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule